// File: doc/BRIEF.md
# Parallel and Byte Result Reader

This block is the device-side read port that hands eight latched 14-bit channel results to a host over a parallel bus. The host frames a transfer with an active-low chip select and pulls an active-low read strobe once per transfer. In word mode every strobe returns one whole channel on a 16-bit bus. The result is sign-extended to fill the word. In byte mode the bus is 8 bits wide and each channel takes two strobes. A byte-order input chooses whether the high byte or the low byte goes first.

Successive strobes walk through channels 1 to 8 and then wrap back to channel 1. A first-data flag marks the transfer that carries channel 1. The falling edge of the converter's busy signal rewinds the read pointer, so each new set of results is read from channel 1. All host-side inputs are asynchronous. They pass through a synchronizer into the system clock domain, and read edges are detected on the synchronized strobe. The bus and the flag are modelled as data outputs with separate output-enable controls, which drive the pad tri-states.

Top module: `result_reader`

## Requirements
- R1: `db_oe_o` is 1 exactly when the synchronized chip select and the synchronized read strobe are both low. `flag_oe_o` is 1 exactly when the synchronized chip select is low.
- R2: In word mode (`byte_mode_i`=0), each transfer places the 14-bit result on `db_o[13:0]` and copies its sign bit (bit 13) into `db_o[15]` and `db_o[14]`.
- R3: After a rewind, successive read strobes return channels 1, 2, up to 8 in that order. Channel k (k=1..8) sits at `results_i[(k-1)*14 +: 14]`.
- R4: `flag_o` goes to 1 on the strobe that presents the first transfer of channel 1 and returns to 0 on the next strobe.
- R5: In byte mode (`byte_mode_i`=1), each transfer drives one byte on `db_o[7:0]` with bit 7 as the byte MSB and holds `db_o[15:8]` at 0. A channel takes two strobes.
- R6: In byte mode with `hi_first_i`=1, the first strobe of a channel returns bits 15:8 of the sign-extended word and the second returns bits 7:0. With `hi_first_i`=0 the two bytes come in the opposite order.
- R7: A falling edge of `busy_i` rewinds the pointer to channel 1 and to the first byte, and clears `flag_o`. When it coincides with a strobe, the rewind takes priority.
- R8: After the last transfer of channel 8, the next strobe returns channel 1 again.
- R9: After reset the pointer is at channel 1, and `db_o`, `flag_o`, `db_oe_o` and `flag_oe_o` are all 0.
- R10: A falling edge on the read strobe while chip select is high is ignored: it neither advances the pointer nor changes `db_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| busy_i | input | 1 | Conversion busy; the falling edge rewinds the pointer |
| byte_mode_i | input | 1 | 1 selects the 8-bit byte bus, 0 the 16-bit word bus |
| hi_first_i | input | 1 | Byte order: 1 sends the high byte first |
| results_i | input | 112 | Eight packed 14-bit results, channel 1 in the lowest bits |
| db_o | output | 16 | Data bus value |
| db_oe_o | output | 1 | Data bus output enable |
| flag_o | output | 1 | First-data flag value |
| flag_oe_o | output | 1 | First-data flag output enable |

## Verification
The hardest states to reach are the wrap from channel 8 back to channel 1 in byte mode and a busy falling edge that lands in the middle of a channel's byte pair. The first needs seventeen strobes in a row, and the second leaves the byte phase half-finished. The bench reads bursts longer than one full pass under both byte orders. It also drops busy after an odd number of byte strobes, and it pulses the read strobe with chip select high. Result values come from a seeded random source, and directed extremes are mixed in: most negative, most positive, zero and minus one.

// File: rtl/result_reader_pkg.sv
package result_reader_pkg;
  localparam int unsigned NUM_CH      = 8;
  localparam int unsigned RES_W       = 14;
  localparam int unsigned BUS_W       = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rr_sync.sv
module rr_sync #(
  parameter int unsigned       W       = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/rr_seq.sv
module rr_seq #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             rewind_i,
  input  logic             byte_mode_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             half_o,
  output logic             flag_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             half_q;
  logic             flag_q;
  logic             ch_done;

  assign ch_done = !byte_mode_i || half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      half_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (rewind_i) begin
      ptr_q  <= '0;
      half_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (strobe_i) begin
      flag_q <= (ptr_q == '0) && !half_q;
      half_q <= byte_mode_i && !half_q;
      if (ch_done) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign half_o = half_q;
  assign flag_o = flag_q;

  // R3: word-mode strobe moves to the next channel
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !rewind_i && !byte_mode_i && ptr_q != LAST |=> ptr_q == $past(ptr_q) + 1'b1);
  // R8: wrap after last channel
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !rewind_i && ch_done && ptr_q == LAST |=> ptr_q == '0);
  // R7: busy fall rewinds
  a_r7_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_i |=> ptr_q == '0 && !half_q && !flag_q);
  // R4: flag drops on a strobe away from channel 1 start
  a_r4_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && (ptr_q != '0 || half_q) |=> !flag_q);
  // R5: byte mode holds the channel on the first byte
  a_r5_two_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !rewind_i && byte_mode_i && !half_q |=> $stable(ptr_q) && half_q);
endmodule

// File: rtl/rr_fmt.sv
module rr_fmt #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned RES_W  = 14,
  parameter int unsigned BUS_W  = 16,
  localparam int unsigned PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned HB_W  = BUS_W / 2
) (
  input  logic [NUM_CH*RES_W-1:0] results_i,
  input  logic [PTR_W-1:0]        ptr_i,
  input  logic                    half_i,
  input  logic                    byte_mode_i,
  input  logic                    hi_first_i,
  output logic [BUS_W-1:0]        data_o
);
  logic [RES_W-1:0] res;
  logic [BUS_W-1:0] word;
  logic             take_hi;

  assign res     = results_i[ptr_i*RES_W +: RES_W];
  assign word    = {{(BUS_W-RES_W){res[RES_W-1]}}, res};
  assign take_hi = hi_first_i ^ half_i;

  always_comb begin
    if (byte_mode_i)
      data_o = {{(BUS_W-HB_W){1'b0}}, take_hi ? word[BUS_W-1 -: HB_W] : word[HB_W-1:0]};
    else
      data_o = word;
  end
endmodule

// File: rtl/result_reader.sv
module result_reader
  import result_reader_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    rd_ni,
  input  logic                    busy_i,
  input  logic                    byte_mode_i,
  input  logic                    hi_first_i,
  input  logic [NUM_CH*RES_W-1:0] results_i,
  output logic [BUS_W-1:0]        db_o,
  output logic                    db_oe_o,
  output logic                    flag_o,
  output logic                    flag_oe_o
);
  localparam int unsigned PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [4:0]       raw, syn;
  logic             cs_s, rd_s, busy_s, mode_s, hf_s;
  logic             rd_d, busy_d, strobe, rewind;
  logic [PTR_W-1:0] ptr;
  logic             half;
  logic [BUS_W-1:0] fmt_data;
  logic [BUS_W-1:0] db_q;

  assign raw = {hi_first_i, byte_mode_i, busy_i, rd_ni, cs_ni};

  rr_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00011)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {hf_s, mode_s, busy_s, rd_s, cs_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_d   <= 1'b1;
      busy_d <= 1'b0;
    end else begin
      rd_d   <= rd_s;
      busy_d <= busy_s;
    end
  end

  assign strobe = rd_d && !rd_s && !cs_s;
  assign rewind = busy_d && !busy_s;

  rr_seq #(.NUM_CH(NUM_CH)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe), .rewind_i(rewind),
    .byte_mode_i(mode_s), .ptr_o(ptr), .half_o(half), .flag_o(flag_o)
  );

  rr_fmt #(.NUM_CH(NUM_CH), .RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
    .results_i(results_i), .ptr_i(ptr), .half_i(half),
    .byte_mode_i(mode_s), .hi_first_i(hf_s), .data_o(fmt_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     db_q <= '0;
    else if (strobe) db_q <= fmt_data;
  end

  assign db_o      = db_q;
  assign db_oe_o   = !cs_s && !rd_s;
  assign flag_oe_o = !cs_s;

  // R1: bus enable implies flag enable
  a_r1_oe_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_oe_o |-> flag_oe_o);
  // R2: word transfers carry the sign into the top bits
  a_r2_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && !mode_s |=> db_o[BUS_W-1] == db_o[RES_W-1] && db_o[BUS_W-2] == db_o[RES_W-1]);
  // R5: byte transfers keep the upper lane at zero
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe && mode_s |=> db_o[BUS_W-1:BUS_W/2] == '0);
  // R10: no strobe, no bus change
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> $stable(db_o));
endmodule

// File: tb/result_reader_tb.sv
module result_reader_tb;
  localparam int NCH = 8;
  localparam int RW  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, busy = 1'b0, bmode = 1'b0, hfirst = 1'b1;
  logic [NCH*RW-1:0] res = '0;
  logic [15:0] db;
  logic db_oe, flag, flag_oe;

  int checks = 0;
  int errors = 0;
  int ptr_m = 0;
  int half_m = 0;

  always #10 clk = ~clk;

  result_reader u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .busy_i(busy),
    .byte_mode_i(bmode), .hi_first_i(hfirst), .results_i(res),
    .db_o(db), .db_oe_o(db_oe), .flag_o(flag), .flag_oe_o(flag_oe)
  );

  function automatic logic [15:0] exp_word(int ch);
    logic [13:0] r;
    r = res[ch*RW +: RW];
    return {{2{r[13]}}, r};
  endfunction

  function automatic logic [15:0] exp_xfer(int ch, int h);
    logic [15:0] w;
    logic hi;
    w = exp_word(ch);
    if (!bmode) return w;
    hi = (h == 0) ? hfirst : !hfirst;
    return {8'h00, hi ? w[15:8] : w[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rewind();
    busy = 1'b1; wait_clk(5);
    busy = 1'b0; wait_clk(5);
    ptr_m = 0; half_m = 0;
  endtask

  task automatic do_read(input string req);
    logic [15:0] e;
    bit ef;
    e  = exp_xfer(ptr_m, half_m);
    ef = (ptr_m == 0) && (half_m == 0);
    rd_n = 1'b0; wait_clk(6);
    chk(db == e, req, db, e);
    chk(flag == ef, "R4", {15'd0, flag}, {15'd0, ef});
    chk(db_oe == 1'b1, "R1", {15'd0, db_oe}, 16'd1);
    rd_n = 1'b1; wait_clk(5);
    chk(db_oe == 1'b0, "R1", {15'd0, db_oe}, 16'd0);
    if (bmode && half_m == 0) half_m = 1;
    else begin half_m = 0; ptr_m = (ptr_m + 1) % NCH; end
  endtask

  task automatic rand_results(int kind);
    for (int c = 0; c < NCH; c++) begin
      case ((kind + c) % 6)
        0: res[c*RW +: RW] = 14'h2000;
        1: res[c*RW +: RW] = 14'h1FFF;
        2: res[c*RW +: RW] = 14'h0000;
        3: res[c*RW +: RW] = 14'h3FFF;
        default: res[c*RW +: RW] = 14'($urandom);
      endcase
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    wait_clk(3);
    chk(db == 16'h0 && flag == 1'b0 && db_oe == 1'b0 && flag_oe == 1'b0, "R9", db, 16'h0);
    rst_n = 1'b1; wait_clk(4);
    chk(db == 16'h0 && flag_oe == 1'b0, "R9", db, 16'h0);

    for (int round = 0; round < 6; round++) begin
      rand_results(round);
      bmode  = round[0];
      hfirst = round[1];
      wait_clk(4);
      rewind();
      cs_n = 1'b0; wait_clk(4);
      chk(flag_oe == 1'b1 && flag == 1'b0, "R1", {14'd0, flag_oe, flag}, 16'h2);
      for (int k = 0; k < (bmode ? 18 : 9); k++)
        do_read(bmode ? (round[1] ? "R6" : "R5") : (k >= 8 ? "R8" : "R3"));
      cs_n = 1'b1; wait_clk(4);
      chk(flag_oe == 1'b0, "R1", {15'd0, flag_oe}, 16'd0);
    end

    // R10: strobes with chip select high are ignored
    bmode = 1'b0; rand_results(7); wait_clk(4);
    rewind();
    cs_n = 1'b0; wait_clk(4);
    do_read("R2"); do_read("R2");
    cs_n = 1'b1; wait_clk(4);
    begin
      logic [15:0] held;
      held = db;
      for (int k = 0; k < 3; k++) begin
        rd_n = 1'b0; wait_clk(5); rd_n = 1'b1; wait_clk(5);
      end
      chk(db == held, "R10", db, held);
    end
    cs_n = 1'b0; wait_clk(4);
    do_read("R10");

    // R7: rewind midway through a byte pair
    bmode = 1'b1; hfirst = 1'b0; wait_clk(4);
    rewind();
    cs_n = 1'b0; wait_clk(4);
    do_read("R6"); do_read("R6"); do_read("R6");
    rewind();
    do_read("R7"); do_read("R7");
    cs_n = 1'b1; wait_clk(4);

    // R2 directed extremes in word mode
    bmode = 1'b0; rand_results(0); wait_clk(4);
    rewind();
    cs_n = 1'b0; wait_clk(4);
    for (int k = 0; k < NCH; k++) do_read("R2");
    cs_n = 1'b1; wait_clk(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule